// File: doc/BRIEF.md
# Environment Configuration CSR Unit

This block keeps the machine-level and supervisor-level environment configuration registers of a RISC-V style hart. It serves CSR accesses by 12-bit address under the current privilege and the current XLEN (32 or 64). For each access it returns read data and says whether the address is legal at that privilege. Only the fence I/O-implies-memory field (bit 0) holds state. Every other field reads as zero and ignores writes.

The block also drives one flag to the fence logic. When the flag is high, the fence logic must treat a fence's I/O predecessor and successor bits as also ordering memory reads and writes. The flag depends on the privilege the hart is running at. It combines the field from the machine register and the field from the supervisor register.

Read data and the illegal flag are combinational from the request. A write that is legal updates the register on the next rising clock edge.

Top module: `envcfg_csr_unit`

## Requirements
- R1: After reset, both stored bits are 0. Every defined read returns 0, and `fence_io_as_mem` is 0.
- R2: The machine register at address 0x30A is defined only when privilege is machine (encoding 3) and `cfg_has_umode` is 1. Its upper half at address 0x31A additionally needs `cfg_xlen64` = 0.
- R3: The supervisor register at address 0x10A is defined only when `cfg_has_smode` is 1 and privilege is machine (3) or supervisor (1).
- R4: An access with `csr_req` = 1 to an address that is not defined raises `csr_illegal`, returns read data 0 and leaves both registers unchanged. Undefined addresses include all other addresses and privilege encoding 2.
- R5: A defined write to 0x30A or 0x10A sets the stored bit to `csr_wdata[0]` AND `cfg_fiom_ok`. All other bits of the register read as 0 whatever was written.
- R6: With `cfg_xlen64` = 0, a write to 0x31A leaves the machine bit unchanged, and a read of 0x31A returns 0.
- R7: Read data is the register value in bit 0 and zeros above. When `cfg_xlen64` = 0, bits 63..32 of `csr_rdata` are always 0.
- R8: The supervisor register takes bit 0 of the written XLEN-wide value, and its read returns that bit in position 0.
- R9: `fence_io_as_mem` is 0 at privilege 3 and at privilege 2. At privilege 1 it equals the machine bit. At privilege 0 it is the OR of the machine bit and the supervisor bit.
- R10: A write becomes visible only after the rising clock edge that samples `csr_req`, `csr_we` and legality together. A read in the same cycle as the write shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_xlen64 | input | 1 | 1 = XLEN 64, 0 = XLEN 32 |
| cfg_has_umode | input | 1 | User mode implemented |
| cfg_has_smode | input | 1 | Supervisor mode implemented |
| cfg_fiom_ok | input | 1 | Fence I/O-implies-memory field is writable |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| csr_req | input | 1 | CSR access this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | Write data (low 32 bits used under XLEN 32) |
| csr_rdata | output | 64 | Read data, zero when undefined |
| csr_illegal | output | 1 | Request hit no defined register |
| fence_io_as_mem | output | 1 | Fence I/O bits also order memory |

## Verification
The bench checks that a write to the upper-half address on RV32 never reaches the stored bit. A design that merged the halves wrongly would clear or set the bit there. It checks that the flag ignores both bits in machine mode and in the reserved privilege, and that the supervisor bit counts only in user mode. A design that ORed the bits everywhere would order memory for machine code.

The bench writes all-ones with the field locked, and checks that the bit stays clear. It also tries accesses from too low a privilege and checks that they leave state untouched. A design that gated the write on the wrong condition would hand lower modes control of the machine register. Random traffic covers the legality table across every combination of the configuration inputs.

// File: rtl/envcfg_pkg.sv
package envcfg_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;
endpackage

// File: rtl/envcfg_decode.sv
module envcfg_decode
  import envcfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] M_ADDR  = 12'h30A,
  parameter logic [ADDR_W-1:0] MH_ADDR = 12'h31A,
  parameter logic [ADDR_W-1:0] S_ADDR  = 12'h10A
) (
  input  logic [ADDR_W-1:0] addr,
  input  priv_e             priv,
  input  logic              xlen64,
  input  logic              has_u,
  input  logic              has_s,
  output logic              hit_m_lo,
  output logic              hit_m_hi,
  output logic              hit_s,
  output logic              defined
);
  logic at_m;
  logic s_ok;

  always_comb begin
    at_m     = (priv == PRIV_M);
    s_ok     = has_s && ((priv == PRIV_M) || (priv == PRIV_S));
    hit_m_lo = (addr == M_ADDR) && at_m && has_u;
    hit_m_hi = (addr == MH_ADDR) && at_m && has_u && !xlen64;
    hit_s    = (addr == S_ADDR) && s_ok;
    defined  = hit_m_lo || hit_m_hi || hit_s;
  end
endmodule

// File: rtl/envcfg_fiom_reg.sv
module envcfg_fiom_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic supported,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = wr_bit && supported;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  // R5: a write while the field is locked leaves the bit clear
  p_locked_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !supported) |=> (q == 1'b0));
  // R10: without a write the bit holds
  p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/envcfg_fiom_gate.sv
module envcfg_fiom_gate
  import envcfg_pkg::*;
(
  input  priv_e priv,
  input  logic  m_bit,
  input  logic  s_bit,
  output logic  active
);
  always_comb begin
    unique case (priv)
      PRIV_U:  active = m_bit | s_bit;
      PRIV_S:  active = m_bit;
      default: active = 1'b0;
    endcase
  end
endmodule

// File: rtl/envcfg_csr_unit.sv
module envcfg_csr_unit
  import envcfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] M_ADDR  = 12'h30A,
  parameter logic [ADDR_W-1:0] MH_ADDR = 12'h31A,
  parameter logic [ADDR_W-1:0] S_ADDR  = 12'h10A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_xlen64,
  input  logic              cfg_has_umode,
  input  logic              cfg_has_smode,
  input  logic              cfg_fiom_ok,
  input  logic [1:0]        priv,
  input  logic              csr_req,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              csr_illegal,
  output logic              fence_io_as_mem
);
  priv_e       priv_q;
  logic        hit_m_lo, hit_m_hi, hit_s, defined;
  logic        m_fiom, s_fiom;
  logic        m_wr, s_wr;
  logic [DATA_W-1:0] m_word, s_word;
  logic        wdata_unused;

  assign priv_q       = priv_e'(priv);
  assign wdata_unused = ^csr_wdata[DATA_W-1:1];

  envcfg_decode #(.M_ADDR(M_ADDR), .MH_ADDR(MH_ADDR), .S_ADDR(S_ADDR)) u_decode (
    .addr(csr_addr), .priv(priv_q), .xlen64(cfg_xlen64),
    .has_u(cfg_has_umode), .has_s(cfg_has_smode),
    .hit_m_lo(hit_m_lo), .hit_m_hi(hit_m_hi), .hit_s(hit_s), .defined(defined)
  );

  // Upper-half address carries only read-only-zero fields: no enable.
  always_comb begin
    m_wr = csr_req && csr_we && hit_m_lo;
    s_wr = csr_req && csr_we && hit_s;
  end

  envcfg_fiom_reg u_m_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(m_wr), .wr_bit(csr_wdata[0]),
    .supported(cfg_fiom_ok), .q(m_fiom)
  );
  envcfg_fiom_reg u_s_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .wr_bit(csr_wdata[0]),
    .supported(cfg_fiom_ok), .q(s_fiom)
  );

  envcfg_fiom_gate u_gate (
    .priv(priv_q), .m_bit(m_fiom), .s_bit(s_fiom), .active(fence_io_as_mem)
  );

  always_comb begin
    m_word    = {{(DATA_W-1){1'b0}}, m_fiom};
    s_word    = {{(DATA_W-1){1'b0}}, s_fiom};
    csr_rdata = '0;
    if (csr_req) begin
      if (hit_m_lo)
        csr_rdata = cfg_xlen64 ? m_word : {{HALF_W{1'b0}}, m_word[HALF_W-1:0]};
      else if (hit_m_hi)
        csr_rdata = {{HALF_W{1'b0}}, m_word[DATA_W-1:HALF_W]};
      else if (hit_s)
        csr_rdata = cfg_xlen64 ? s_word : {{HALF_W{1'b0}}, s_word[HALF_W-1:0]};
    end
    csr_illegal = csr_req && !defined;
  end

  // R4: undefined access reads zero
  p_illegal_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0));
  // R4: undefined write touches no state
  p_illegal_no_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_illegal && csr_we) |=> ($stable(m_fiom) && $stable(s_fiom)));
  // R2: at most one register selected
  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_m_lo, hit_m_hi, hit_s}));
  // R6: upper-half write keeps the machine bit
  p_high_write_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_we && hit_m_hi) |=> $stable(m_fiom));
  // R7: RV32 reads never carry upper bits
  p_rv32_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_xlen64 |-> (csr_rdata[DATA_W-1:HALF_W] == '0));
  // R9: flag only from a set bit, never in machine mode
  p_flag_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fence_io_as_mem |-> ((m_fiom || s_fiom) && (priv != 2'd3)));
endmodule

// File: tb/envcfg_csr_unit_bench.sv
`timescale 1ns/1ps
module envcfg_csr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_xlen64, cfg_has_umode, cfg_has_smode, cfg_fiom_ok;
  logic [1:0]  priv;
  logic        csr_req, csr_we;
  logic [11:0] csr_addr;
  logic [63:0] csr_wdata;
  logic [63:0] csr_rdata;
  logic        csr_illegal, fence_io_as_mem;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit mb = 1'b0, sb = 1'b0;

  always #4 clk = ~clk;

  envcfg_csr_unit u_envcfg_csr_unit (
    .clk(clk), .rst_n(rst_n), .cfg_xlen64(cfg_xlen64), .cfg_has_umode(cfg_has_umode),
    .cfg_has_smode(cfg_has_smode), .cfg_fiom_ok(cfg_fiom_ok), .priv(priv),
    .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal), .fence_io_as_mem(fence_io_as_mem)
  );

  function automatic bit f_def(logic [11:0] a, logic [1:0] p, bit x64, bit hu, bit hs);
    if (a == 12'h30A) return (p == 2'd3) && hu;
    if (a == 12'h31A) return (p == 2'd3) && hu && !x64;
    if (a == 12'h10A) return hs && (p == 2'd3 || p == 2'd1);
    return 1'b0;
  endfunction

  function automatic logic [63:0] f_rd(logic [11:0] a, bit d, bit m, bit s);
    if (!d) return 64'd0;
    if (a == 12'h30A) return {63'd0, m};
    if (a == 12'h10A) return {63'd0, s};
    return 64'd0;
  endfunction

  function automatic bit f_flag(logic [1:0] p, bit m, bit s);
    case (p)
      2'd0: return m | s;
      2'd1: return m;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, compare combinational outputs, update model at posedge.
  task automatic step(bit x64, bit hu, bit hs, bit ok, logic [1:0] p, bit rq, bit we,
                      logic [11:0] a, logic [63:0] wd, string tag);
    bit d;
    @(negedge clk);
    cfg_xlen64 = x64; cfg_has_umode = hu; cfg_has_smode = hs; cfg_fiom_ok = ok;
    priv = p; csr_req = rq; csr_we = we; csr_addr = a; csr_wdata = wd;
    #1;
    d = f_def(a, p, x64, hu, hs);
    chk(csr_illegal == (rq && !d), {tag, " illegal R2 R3 R4"}, {63'd0, csr_illegal}, {63'd0, rq && !d});
    chk(csr_rdata == (rq ? f_rd(a, d, mb, sb) : 64'd0), {tag, " rdata R7 R10"},
        csr_rdata, rq ? f_rd(a, d, mb, sb) : 64'd0);
    chk(fence_io_as_mem == f_flag(p, mb, sb), {tag, " flag R9"},
        {63'd0, fence_io_as_mem}, {63'd0, f_flag(p, mb, sb)});
    @(posedge clk);
    if (rq && we && d) begin
      if (a == 12'h30A) mb = wd[0] && ok;
      if (a == 12'h10A) sb = wd[0] && ok;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [11:0] a;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst_n = 1'b0;
    cfg_xlen64 = 1; cfg_has_umode = 1; cfg_has_smode = 1; cfg_fiom_ok = 1;
    priv = 2'd3; csr_req = 0; csr_we = 0; csr_addr = 12'h30A; csr_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    step(1, 1, 1, 1, 2'd3, 1, 0, 12'h30A, 0, "R1 reset m");
    step(1, 1, 1, 1, 2'd0, 1, 0, 12'h10A, 0, "R1 reset flag");
    // R5: all-ones write keeps only bit 0; R10 same-cycle read shows old
    step(1, 1, 1, 1, 2'd3, 1, 1, 12'h30A, '1, "R5 R10 write ones");
    step(1, 1, 1, 1, 2'd3, 1, 0, 12'h30A, 0, "R5 readback");
    chk(csr_rdata == 64'd1, "R5 direct readback", csr_rdata, 64'd1);
    // R6: RV32 upper-half write leaves bit 0 set
    step(0, 1, 1, 1, 2'd3, 1, 1, 12'h31A, '1, "R6 high write");
    step(0, 1, 1, 1, 2'd3, 1, 0, 12'h30A, 0, "R6 low readback");
    chk(csr_rdata == 64'd1, "R6 bit kept", csr_rdata, 64'd1);
    // R9: flag by privilege with only machine bit set
    step(1, 1, 1, 1, 2'd1, 0, 0, 0, 0, "R9 sup");
    chk(fence_io_as_mem == 1'b1, "R9 sup direct", {63'd0, fence_io_as_mem}, 64'd1);
    step(1, 1, 1, 1, 2'd3, 0, 0, 0, 0, "R9 mach");
    chk(fence_io_as_mem == 1'b0, "R9 mach direct", {63'd0, fence_io_as_mem}, 64'd0);
    // R5: locked write clears
    step(1, 1, 1, 0, 2'd3, 1, 1, 12'h30A, '1, "R5 locked");
    step(1, 1, 1, 0, 2'd3, 1, 0, 12'h30A, 0, "R5 locked readback");
    chk(csr_rdata == 64'd0, "R5 locked direct", csr_rdata, 64'd0);
    // R8: supervisor write from supervisor mode, R9 user OR
    step(0, 1, 1, 1, 2'd1, 1, 1, 12'h10A, 64'hFFFF_FFFF_0000_0001, "R8 s write");
    step(0, 1, 1, 1, 2'd0, 0, 0, 0, 0, "R9 user");
    chk(fence_io_as_mem == 1'b1, "R9 user direct", {63'd0, fence_io_as_mem}, 64'd1);
    // R4: illegal write from supervisor to machine reg, state checked after
    step(1, 1, 1, 1, 2'd1, 1, 1, 12'h30A, '1, "R4 illegal write");
    step(1, 1, 1, 1, 2'd3, 1, 0, 12'h30A, 0, "R4 unchanged");
    chk(csr_rdata == 64'd0, "R4 unchanged direct", csr_rdata, 64'd0);
    step(1, 1, 1, 1, 2'd2, 1, 1, 12'h10A, 0, "R4 reserved priv");
    step(1, 1, 1, 1, 2'd1, 1, 0, 12'h10A, 0, "R4 s unchanged");
    chk(csr_rdata == 64'd1, "R4 s direct", csr_rdata, 64'd1);
    // R2: upper half undefined on RV64, machine reg needs user mode
    step(1, 1, 1, 1, 2'd3, 1, 0, 12'h31A, 0, "R2 high on rv64");
    step(1, 0, 1, 1, 2'd3, 1, 0, 12'h30A, 0, "R2 no umode");
    // R3: supervisor reg needs supervisor mode
    step(1, 1, 0, 1, 2'd3, 1, 0, 12'h10A, 0, "R3 no smode");

    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 3))
        0: a = 12'h30A;
        1: a = 12'h31A;
        2: a = 12'h10A;
        default: a = 12'($urandom);
      endcase
      step(1'($urandom), ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
           ($urandom_range(0, 3) != 0), 2'($urandom), ($urandom_range(0, 7) != 0),
           1'($urandom), a, {$urandom, $urandom}, "rand");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule